// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block links two W-bit ports, A and B, and keeps one storage register per direction. Each port is modelled with a separate input, output and output-enable signal, so no internal tri-state nets are formed. Each register samples the value present on its source port line on the rising edge of its own clock. A per-direction select decides whether the far port is fed live data or the stored word. The two direction enables have opposite polarities.

A line-resolution stage works out what each port line carries. In order of priority, that is an external driver flagged valid, this block's own drive, or a keeper value. The keeper reproduces the way a bus holds its last level when nothing drives it. When both ports drive each other with live data, the keepers break the loop, so no combinational cycle is built. The keepers are sampled on a free-running keeper clock.

Top module: `dir_store_xcvr`

## Requirements
- R1: On each rising edge of `clk_ab` the A-to-B register loads the current A line value, whatever the selects and enables are doing. With `sel_ab`=1 the stored word shows on `b_out`.
- R2: On each rising edge of `clk_ba` the B-to-A register loads the current B line value, whatever the selects and enables are doing. With `sel_ba`=1 the stored word shows on `a_out`.
- R3: `b_out` carries the A line value when `sel_ab`=0 and the A-to-B register when `sel_ab`=1.
- R4: `a_out` carries the B line value when `sel_ba`=0 and the B-to-A register when `sel_ba`=1.
- R5: `b_oe` equals `en_ab` (active high) while out of reset.
- R6: `a_oe` is high exactly when `en_ba_n` is low (active low) while out of reset.
- R7: With `en_ab`=0 and `en_ba_n`=1 neither output enable is asserted, and both registers still capture on their clocks.
- R8: With B fed live from A (`en_ab`=1, `sel_ab`=0) and no external driver on B, a `clk_ba` edge stores the A value into the B-to-A register. The mirrored case stores the B value into the A-to-B register.
- R9: A line resolves to its input when its valid flag is high. Otherwise, if its port drives, it resolves to what it is driven with. Otherwise it resolves to its keeper. The keeper loads the line value on each rising `keep_clk` edge. With both ports enabled, both selects live and no external driver, both lines keep their last values.
- R10: While `rst_n` is low, both registers and both keepers are zero and both output enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset |
| keep_clk | input | 1 | Clock that samples the line keepers |
| clk_ab | input | 1 | A-to-B register clock |
| clk_ba | input | 1 | B-to-A register clock |
| en_ab | input | 1 | Drive enable for port B, active high |
| en_ba_n | input | 1 | Drive enable for port A, active low |
| sel_ab | input | 1 | Source for port B: 0 live, 1 stored |
| sel_ba | input | 1 | Source for port A: 0 live, 1 stored |
| a_in | input | W | Value of the external driver on port A |
| a_ext_vld | input | 1 | An external driver on port A is active |
| a_out | output | W | Value this block drives onto port A |
| a_oe | output | 1 | Port A drive enable |
| b_in | input | W | Value of the external driver on port B |
| b_ext_vld | input | 1 | An external driver on port B is active |
| b_out | output | W | Value this block drives onto port B |
| b_oe | output | 1 | Port B drive enable |

## Verification
The sweep walks every enable and select setting against every pattern of external-driver flags, and pulses the two register clocks in varied combinations. A design that swapped an enable's polarity, or swapped the live and stored mux inputs, would put the wrong word or the wrong enable on a port. Directed cases cover three corners. In isolation, a design that gated capture on the enables would leave the registers stale. In the both-registers copy, a design that sampled the raw B input instead of the resolved line would store the outside value. In the live loop, a design without keepers would lose the held value once the outside driver leaves.

// File: rtl/dir_store_xcvr_pkg.sv
package dir_store_xcvr_pkg;
   typedef enum logic {SRC_LIVE = 1'b0, SRC_STORED = 1'b1} src_sel_e;
   localparam int MIN_WIDTH = 1;
endpackage

// File: rtl/xcvr_store.sv
module xcvr_store #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= d;
   end

   AST_STORE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> q == $past(d)); // R1
endmodule

// File: rtl/xcvr_keep.sv
module xcvr_keep #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] line,
   output logic [W-1:0] held
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) held <= '0;
      else        held <= line;
   end
endmodule

// File: rtl/xcvr_line.sv
module xcvr_line #(
   parameter int W = 8
) (
   input  logic         my_ext,
   input  logic [W-1:0] my_in,
   input  logic         my_oe,
   input  logic         my_sel,
   input  logic [W-1:0] my_reg,
   input  logic [W-1:0] my_hold,
   input  logic         far_ext,
   input  logic [W-1:0] far_in,
   input  logic         far_oe,
   input  logic         far_sel,
   input  logic [W-1:0] far_reg,
   input  logic [W-1:0] far_hold,
   output logic [W-1:0] line
);
   logic [W-1:0] far_view;

   always_comb begin
      if (far_ext)       far_view = far_in;
      else if (!far_oe)  far_view = far_hold;
      else if (far_sel)  far_view = far_reg;
      else               far_view = my_hold;
   end

   always_comb begin
      if (my_ext)        line = my_in;
      else if (!my_oe)   line = my_hold;
      else if (my_sel)   line = my_reg;
      else               line = far_view;
   end

   always_comb begin
      if (my_ext) AST_EXT_WINS: assert (line == my_in); // R9
   end
endmodule

// File: rtl/dir_store_xcvr.sv
module dir_store_xcvr
   import dir_store_xcvr_pkg::*;
#(
   parameter int W = 8
) (
   input  logic         rst_n,
   input  logic         keep_clk,
   input  logic         clk_ab,
   input  logic         clk_ba,
   input  logic         en_ab,
   input  logic         en_ba_n,
   input  logic         sel_ab,
   input  logic         sel_ba,
   input  logic [W-1:0] a_in,
   input  logic         a_ext_vld,
   output logic [W-1:0] a_out,
   output logic         a_oe,
   input  logic [W-1:0] b_in,
   input  logic         b_ext_vld,
   output logic [W-1:0] b_out,
   output logic         b_oe
);
   localparam int MSB = W - 1;

   generate
      if (W < MIN_WIDTH) begin : g_bad_width
         initial $error("dir_store_xcvr: W must be at least %0d", MIN_WIDTH);
      end
   endgenerate

   logic [MSB:0] reg_ab, reg_ba;
   logic [MSB:0] hold_a, hold_b;
   logic [MSB:0] line_a, line_b;
   src_sel_e     src_b, src_a;

   assign src_b = src_sel_e'(sel_ab);
   assign src_a = src_sel_e'(sel_ba);
   assign b_oe  = rst_n & en_ab;
   assign a_oe  = rst_n & ~en_ba_n;

   xcvr_line #(.W(W)) u_line_a (
      .my_ext(a_ext_vld), .my_in(a_in), .my_oe(a_oe), .my_sel(sel_ba),
      .my_reg(reg_ba), .my_hold(hold_a),
      .far_ext(b_ext_vld), .far_in(b_in), .far_oe(b_oe), .far_sel(sel_ab),
      .far_reg(reg_ab), .far_hold(hold_b),
      .line(line_a));

   xcvr_line #(.W(W)) u_line_b (
      .my_ext(b_ext_vld), .my_in(b_in), .my_oe(b_oe), .my_sel(sel_ab),
      .my_reg(reg_ab), .my_hold(hold_b),
      .far_ext(a_ext_vld), .far_in(a_in), .far_oe(a_oe), .far_sel(sel_ba),
      .far_reg(reg_ba), .far_hold(hold_a),
      .line(line_b));

   xcvr_store #(.W(W)) u_store_ab (.clk(clk_ab), .rst_n(rst_n), .d(line_a), .q(reg_ab));
   xcvr_store #(.W(W)) u_store_ba (.clk(clk_ba), .rst_n(rst_n), .d(line_b), .q(reg_ba));

   xcvr_keep #(.W(W)) u_keep_a (.clk(keep_clk), .rst_n(rst_n), .line(line_a), .held(hold_a));
   xcvr_keep #(.W(W)) u_keep_b (.clk(keep_clk), .rst_n(rst_n), .line(line_b), .held(hold_b));

   always_comb begin
      b_out = (src_b == SRC_STORED) ? reg_ab : line_a;
      a_out = (src_a == SRC_STORED) ? reg_ba : line_b;
   end

   always_comb begin
      if (b_oe && !sel_ab && a_ext_vld)
         AST_LIVE_TO_B: assert (b_out == a_in); // R3
      if (a_oe && !sel_ba && b_ext_vld)
         AST_LIVE_TO_A: assert (a_out == b_in); // R4
      if (!rst_n)
         AST_RESET_QUIET: assert (!a_oe && !b_oe && reg_ab == '0 && reg_ba == '0); // R10
   end

   AST_LOOP_HOLDS: assert property (@(posedge keep_clk) disable iff (!rst_n)
      (a_oe && b_oe && !sel_ab && !sel_ba && !a_ext_vld && !b_ext_vld &&
       $past(a_oe && b_oe && !sel_ab && !sel_ba && !a_ext_vld && !b_ext_vld))
      |-> ($stable(a_out) && $stable(b_out))); // R9
endmodule

// File: tb/dir_store_xcvr_bench.sv
module dir_store_xcvr_bench;
   localparam int W = 8;

   logic         rst_n, keep_clk, clk_ab, clk_ba;
   logic         en_ab, en_ba_n, sel_ab, sel_ba;
   logic [W-1:0] a_in, b_in, a_out, b_out;
   logic         a_ext_vld, b_ext_vld, a_oe, b_oe;

   int errs = 0;
   int checks = 0;
   logic [W-1:0] m_ab, m_ba, m_ha, m_hb;

   dir_store_xcvr #(.W(W)) u_dir_store_xcvr (
      .rst_n(rst_n), .keep_clk(keep_clk), .clk_ab(clk_ab), .clk_ba(clk_ba),
      .en_ab(en_ab), .en_ba_n(en_ba_n), .sel_ab(sel_ab), .sel_ba(sel_ba),
      .a_in(a_in), .a_ext_vld(a_ext_vld), .a_out(a_out), .a_oe(a_oe),
      .b_in(b_in), .b_ext_vld(b_ext_vld), .b_out(b_out), .b_oe(b_oe));

   initial keep_clk = 1'b0;
   always #10 keep_clk = ~keep_clk;

   task automatic chk(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
      checks++;
      if (got !== exp) begin
         errs++;
         $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
      end
   endtask

   function automatic logic [W-1:0] mline(input logic me, input logic [W-1:0] mi,
      input logic mo, input logic ms, input logic [W-1:0] mr, input logic [W-1:0] mh,
      input logic fe, input logic [W-1:0] fi, input logic fo, input logic fs,
      input logic [W-1:0] fr, input logic [W-1:0] fh);
      if (me) return mi;
      if (!mo) return mh;
      if (ms) return mr;
      if (fe) return fi;
      if (!fo) return fh;
      if (fs) return fr;
      return mh;
   endfunction

   function automatic logic [W-1:0] la();
      return mline(a_ext_vld, a_in, !en_ba_n, sel_ba, m_ba, m_ha,
                   b_ext_vld, b_in, en_ab, sel_ab, m_ab, m_hb);
   endfunction
   function automatic logic [W-1:0] lb();
      return mline(b_ext_vld, b_in, en_ab, sel_ab, m_ab, m_hb,
                   a_ext_vld, a_in, !en_ba_n, sel_ba, m_ba, m_ha);
   endfunction

   task automatic check_ports(input string when);
      chk({"R5 b_oe ", when}, {7'd0, b_oe}, {7'd0, en_ab});
      chk({"R6 a_oe ", when}, {7'd0, a_oe}, {7'd0, !en_ba_n});
      chk({"R3 b_out ", when}, b_out, sel_ab ? m_ab : la());
      chk({"R4 a_out ", when}, a_out, sel_ba ? m_ba : lb());
   endtask

   task automatic pulse_ab();
      m_ab = la();
      #1 clk_ab = 1'b1;
      #1 clk_ab = 1'b0;
   endtask
   task automatic pulse_ba();
      m_ba = lb();
      #1 clk_ba = 1'b1;
      #1 clk_ba = 1'b0;
   endtask

   task automatic keep_edge();
      logic [W-1:0] na, nb;
      @(posedge keep_clk);
      na = la();
      nb = lb();
      m_ha = na;
      m_hb = nb;
   endtask

   task automatic drive(input logic eab, input logic ebn, input logic sab, input logic sba,
                        input logic ae, input logic [W-1:0] av,
                        input logic be, input logic [W-1:0] bv);
      @(negedge keep_clk);
      en_ab = eab; en_ba_n = ebn; sel_ab = sab; sel_ba = sba;
      a_ext_vld = ae; a_in = av; b_ext_vld = be; b_in = bv;
      #1;
   endtask

   initial begin
      #20000000;
      errs++;
      $display("FAIL watchdog: got hang expected completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      rst_n = 1'b0; clk_ab = 1'b0; clk_ba = 1'b0;
      en_ab = 1'b1; en_ba_n = 1'b0; sel_ab = 1'b1; sel_ba = 1'b1;
      a_in = 8'hFF; b_in = 8'hFF; a_ext_vld = 1'b1; b_ext_vld = 1'b1;
      m_ab = '0; m_ba = '0; m_ha = '0; m_hb = '0;
      repeat (3) @(posedge keep_clk);
      #1;
      // R10: reset state, registers zero and both enables quiet
      chk("R10 b_oe in reset", {7'd0, b_oe}, 8'd0);
      chk("R10 a_oe in reset", {7'd0, a_oe}, 8'd0);
      chk("R10 ab reg in reset", b_out, 8'h00);
      chk("R10 ba reg in reset", a_out, 8'h00);
      @(negedge keep_clk);
      rst_n = 1'b1;
      a_ext_vld = 1'b0; b_ext_vld = 1'b0;
      #1;
      keep_edge();

      // R1: A-to-B capture, observed as stored data on B
      drive(1, 1, 1, 1, 1, 8'h5A, 0, 8'h00);
      pulse_ab();
      #1 chk("R1 stored A on b_out", b_out, 8'h5A);
      keep_edge();
      // R2: B-to-A capture, observed as stored data on A
      drive(0, 0, 1, 1, 0, 8'h00, 1, 8'hC3);
      pulse_ba();
      #1 chk("R2 stored B on a_out", a_out, 8'hC3);
      keep_edge();

      // R7: isolation, registers still capture
      drive(0, 1, 1, 1, 1, 8'h11, 1, 8'h22);
      pulse_ab(); pulse_ba();
      #1;
      chk("R7 b_oe isolated", {7'd0, b_oe}, 8'd0);
      chk("R7 a_oe isolated", {7'd0, a_oe}, 8'd0);
      chk("R7 ab reg captured", b_out, 8'h11);
      chk("R7 ba reg captured", a_out, 8'h22);
      keep_edge();

      // R8: A stored into both registers via the live B path
      drive(1, 1, 0, 1, 1, 8'h6D, 0, 8'h99);
      pulse_ab(); pulse_ba();
      drive(1, 1, 1, 1, 0, 8'h00, 0, 8'h00);
      chk("R8 A copy in ab reg", b_out, 8'h6D);
      chk("R8 A copy in ba reg", a_out, 8'h6D);
      keep_edge();
      // R8: mirrored, B stored into both
      drive(0, 0, 1, 0, 0, 8'h44, 1, 8'hB2);
      pulse_ab(); pulse_ba();
      drive(1, 1, 1, 1, 0, 8'h00, 0, 8'h00);
      chk("R8 B copy in ab reg", b_out, 8'hB2);
      chk("R8 B copy in ba reg", a_out, 8'hB2);
      keep_edge();

      // R9: live loop keeps the last externally driven value
      drive(1, 0, 0, 0, 1, 8'h3C, 0, 8'h00);
      keep_edge();
      drive(1, 0, 0, 0, 0, 8'hFF, 0, 8'hEE);
      for (int k = 0; k < 4; k++) begin
         chk("R9 loop hold a_out", a_out, 8'h3C);
         chk("R9 loop hold b_out", b_out, 8'h3C);
         keep_edge();
         #1;
      end

      // R3 R4 R5 R6 R1 R2 R9: sweep over every enable, select and driver pattern
      for (int i = 0; i < 256; i++) begin
         drive(i[0], i[1], i[2], i[3], i[4], 8'(i * 37 + 5), i[5], 8'(i * 91 + 3));
         check_ports("before pulses");
         if (i[6]) pulse_ab();
         if (i[7] || i[4]) pulse_ba();
         #1 check_ports("after pulses");
         keep_edge();
      end

      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule